// File: doc/BRIEF.md
# Ethernet Transmit Frame Padder with CRC-32 Trailer

This streaming stage sits in an Ethernet transmit path, after the frame store and before the serializer. Frames arrive one byte per beat with valid, last and ready handshaking. Data bytes go straight through with no added latency. After the last data byte the stage can append zero bytes until the frame reaches the minimum length. It can then append a four-byte CRC-32 check sequence that covers the data and the padding.

Three controls decide what is added. A pad enable turns on minimum-length padding. A global check-sequence inhibit suppresses the trailer. A per-frame request flag forces the trailer for one frame. All three are sampled on the beat that carries the last data byte. When padding is enabled, the trailer is always appended, whatever the other two controls say. While the stage emits pad or trailer bytes it holds its upstream ready low, so the next frame waits.

Top module: `eth_tx_padfcs`

## Requirements
- R1: While data bytes are passing, out_valid equals in_valid, out_data equals in_data and in_ready equals out_ready. Each byte appears once, unchanged and in order.
- R2: If pad_en is high on the last data beat and the frame holds fewer than 60 data bytes, bytes of value 0x00 follow the data until data plus pad is 60 bytes. The trailer follows, giving 64 bytes in total.
- R3: A frame of 60 or more data bytes gets no pad bytes. A frame sent with pad_en low gets no pad bytes.
- R4: The 4-byte trailer is appended when pad_en is high, or fcs_off is low, or in_add_fcs is high, all sampled on the last data beat. Otherwise out_last is raised on the last data byte and nothing is appended.
- R5: The trailer is the CRC-32 with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF. It is taken over all data and pad bytes and the result is complemented. It is sent least significant byte first. For the nine bytes 0x31..0x39 the trailer is 26 39 F4 CB.
- R6: out_last is high on exactly one output byte per frame: the final one.
- R7: in_ready stays low from the acceptance of the last data byte until the last pad or trailer byte has been accepted downstream.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value on the next cycle.
- R9: After reset, out_valid is low when no input is offered and in_ready follows out_ready. A reset in the middle of a frame tail drops that frame. The next frame starts with a fresh CRC and a byte count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_en | input | 1 | Enables padding to minimum length; also forces the trailer |
| fcs_off | input | 1 | Global inhibit of the CRC trailer |
| in_data | input | 8 | Upstream data byte |
| in_valid | input | 1 | Upstream byte valid |
| in_last | input | 1 | Upstream byte is the last data byte of the frame |
| in_add_fcs | input | 1 | Per-frame trailer request, sampled on the last beat |
| in_ready | output | 1 | Stage accepts the upstream byte |
| out_data | output | 8 | Downstream byte |
| out_valid | output | 1 | Downstream byte valid |
| out_last | output | 1 | Downstream byte ends the frame |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
If the CRC register is corrupted, or not reseeded between frames, the error shows only in the four trailer bytes. It appears one cycle after the last data or pad byte is accepted, so each frame is compared byte for byte, including a frame with a known trailer. A wrong byte count or a stuck state shows as a frame of the wrong length, or as in_ready rising during the tail. That is visible within the same frame. Back-to-back frames and a reset in the middle of the padding show state that leaked across a frame boundary on the very next frame.

// File: rtl/eth_txpad_pkg.sv
package eth_txpad_pkg;
    localparam int unsigned CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2
    } tx_state_e;

    // One byte of a reflected CRC, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_byte_step(
        input logic [CRC_W-1:0] crc_in,
        input logic [7:0]       data,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] acc;
        acc = crc_in ^ {{(CRC_W-8){1'b0}}, data};
        for (int b = 0; b < 8; b++) begin
            acc = acc[0] ? ((acc >> 1) ^ poly) : (acc >> 1);
        end
        return acc;
    endfunction
endpackage

// File: rtl/eth_tx_crc_step.sv
module eth_tx_crc_step
    import eth_txpad_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY_REFL
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       data_in,
    output logic [CRC_W-1:0] crc_out
);
    always_comb begin
        crc_out = crc_byte_step(crc_in, data_in, POLY);
    end
endmodule

// File: rtl/eth_tx_len_ctr.sv
module eth_tx_len_ctr #(
    parameter int unsigned LIMIT = 60,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] cnt_q
);
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CW'(LIMIT))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/eth_tx_padfcs.sv
module eth_tx_padfcs
    import eth_txpad_pkg::*;
#(
    parameter int unsigned MIN_FRAME = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_en,
    input  logic       fcs_off,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       in_add_fcs,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_last,
    input  logic       out_ready
);
    localparam int unsigned FCS_BYTES = CRC_W / 8;
    localparam int unsigned DATA_MIN  = MIN_FRAME - FCS_BYTES;
    localparam int unsigned CNT_W     = $clog2(DATA_MIN + 1);
    localparam int unsigned IDX_W     = $clog2(FCS_BYTES);

    typedef struct packed {
        tx_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [CRC_W-1:0] crc;
    } ctl_t;

    ctl_t             r_q, r_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_inc, cnt_clr;
    logic [7:0]       crc_data;
    logic [CRC_W-1:0] crc_upd;
    logic [CRC_W-1:0] fcs_shift;
    logic             want_fcs, short_frame;

    eth_tx_len_ctr #(.LIMIT(DATA_MIN)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .clr   (cnt_clr),
        .cnt_q (cnt_q)
    );

    eth_tx_crc_step #(.POLY(CRC_POLY_REFL)) u_crc (
        .crc_in  (r_q.crc),
        .data_in (crc_data),
        .crc_out (crc_upd)
    );

    always_comb begin
        r_d         = r_q;
        in_ready    = 1'b0;
        out_valid   = 1'b0;
        out_data    = '0;
        out_last    = 1'b0;
        cnt_inc     = 1'b0;
        cnt_clr     = 1'b0;
        crc_data    = in_data;
        // Padding forces the trailer regardless of the inhibit controls.
        want_fcs    = pad_en | ~fcs_off | in_add_fcs;
        // cnt_q counts bytes before the current one.
        short_frame = pad_en && (cnt_q < CNT_W'(DATA_MIN - 1));
        fcs_shift   = ~r_q.crc >> {r_q.idx, 3'b000};

        unique case (r_q.st)
            ST_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = in_last & ~want_fcs;
                if (in_valid && out_ready) begin
                    cnt_inc = 1'b1;
                    r_d.crc = crc_upd;
                    if (in_last) begin
                        if (short_frame) begin
                            r_d.st = ST_PAD;
                        end else if (want_fcs) begin
                            r_d.st  = ST_FCS;
                            r_d.idx = '0;
                        end else begin
                            r_d.crc = '1;
                            cnt_clr = 1'b1;
                        end
                    end
                end
            end
            ST_PAD: begin
                crc_data  = 8'h00;
                out_valid = 1'b1;
                if (out_ready) begin
                    cnt_inc = 1'b1;
                    r_d.crc = crc_upd;
                    if (cnt_q == CNT_W'(DATA_MIN - 1)) begin
                        r_d.st  = ST_FCS;
                        r_d.idx = '0;
                    end
                end
            end
            ST_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_shift[7:0];
                out_last  = (r_q.idx == IDX_W'(FCS_BYTES - 1));
                if (out_ready) begin
                    if (out_last) begin
                        r_d.st  = ST_DATA;
                        r_d.idx = '0;
                        r_d.crc = '1;
                        cnt_clr = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: begin
                r_d.st = ST_DATA;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_DATA, idx: '0, crc: '1};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/eth_tx_padfcs_chk.sv
module eth_tx_padfcs_chk #(
    parameter int unsigned MIN_FRAME = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pad_en,
    input logic [7:0] in_data,
    input logic       in_valid,
    input logic       in_last,
    input logic       in_ready,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_last,
    input logic       out_ready
);
    logic       tail_q;
    logic       pad_mode_q;
    logic [7:0] ocnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q     <= 1'b0;
            pad_mode_q <= 1'b0;
            ocnt_q     <= '0;
        end else begin
            if (in_valid && in_ready && in_last && !out_last) begin
                tail_q     <= 1'b1;
                pad_mode_q <= pad_en;
            end
            if (out_valid && out_ready && out_last) begin
                tail_q <= 1'b0;
                ocnt_q <= '0;
            end else if (out_valid && out_ready && ocnt_q != 8'hFF) begin
                ocnt_q <= ocnt_q + 1'b1;
            end
        end
    end

    a_r1_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !tail_q |-> (in_ready == out_ready));

    a_r1_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!tail_q && in_valid) |-> (out_valid && out_data == in_data));

    a_r7_tail_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        tail_q |-> !in_ready);

    a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r2_min_length: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q && pad_mode_q && out_valid && out_ready && out_last)
            |-> (int'(ocnt_q) + 1 >= int'(MIN_FRAME)));
endmodule

bind eth_tx_padfcs eth_tx_padfcs_chk #(.MIN_FRAME(MIN_FRAME)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_en    (pad_en),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/eth_tx_padfcs_tb.sv
module eth_tx_padfcs_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pad_en, fcs_off, in_add_fcs;
    logic [7:0] in_data;
    logic       in_valid, in_last, in_ready;
    logic [7:0] out_data;
    logic       out_valid, out_last, out_ready;

    always #10 clk = ~clk;

    eth_tx_padfcs u_dut (
        .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .fcs_off(fcs_off),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_add_fcs(in_add_fcs), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_ready(out_ready)
    );

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] exp_b [0:255];
    logic [7:0] got_b [0:255];
    int         exp_n, got_n;

    // {len, pad_en, fcs_off, add_fcs, seed}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {8'd10, 1'b1, 1'b1, 1'b0, 8'h10},  // R2: pad overrides inhibit
        {8'd59, 1'b1, 1'b0, 1'b0, 8'h20},  // R2: one pad byte
        {8'd60, 1'b1, 1'b0, 1'b0, 8'h30},  // R3: exact minimum, no pad
        {8'd75, 1'b1, 1'b1, 1'b0, 8'h40},  // R3: long frame
        {8'd10, 1'b0, 1'b0, 1'b0, 8'h50},  // R4: trailer, no pad
        {8'd10, 1'b0, 1'b1, 1'b0, 8'h60},  // R4: no trailer
        {8'd10, 1'b0, 1'b1, 1'b1, 8'h70},  // R4: per-frame request
        {8'd1,  1'b1, 1'b0, 1'b0, 8'h80},  // R2: 59 pad bytes
        {8'd1,  1'b0, 1'b1, 1'b0, 8'h90},  // R4: single bare byte
        {8'd64, 1'b0, 1'b0, 1'b1, 8'hA0}   // R3: pad off, long
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[0] ^ exp_b[i][j];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic run_frame(input int len, input bit pe, input bit off,
                             input bit add, input int seed, input bit bp);
        int   idx = 0;
        int   cyc = 0;
        bit   done = 0;
        int   tail_viol = 0;
        int   hold_viol = 0;
        int   data_err = 0;
        bit   held = 0;
        logic [7:0] held_d = '0;
        logic [31:0] crc;

        exp_n = 0;
        for (int i = 0; i < len; i++) exp_b[exp_n++] = 8'(seed + i);
        if (pe) while (exp_n < 60) exp_b[exp_n++] = 8'h00;
        if (pe || !off || add) begin
            crc = ref_crc(exp_n);
            for (int k = 0; k < 4; k++) exp_b[exp_n++] = crc[8*k +: 8];
        end

        got_n = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            pad_en = pe; fcs_off = off;
            out_ready = bp ? (cyc % 3 != 0) : 1'b1;
            in_valid = 1'b1;
            if (idx < len) begin
                in_data    = 8'(seed + idx);
                in_last    = (idx == len - 1);
                in_add_fcs = (idx == len - 1) ? add : ~add;
            end else begin
                in_data = 8'hEE; in_last = 1'b0; in_add_fcs = 1'b0;
            end
            #1;
            if (held && (!out_valid || out_data !== held_d)) hold_viol++;
            held   = out_valid && !out_ready;
            held_d = out_data;
            if (idx >= len && in_ready) tail_viol++;
            if (out_valid && out_ready) begin
                if (got_n < 256) got_b[got_n] = out_data;
                got_n++;
                if (out_last) done = 1;
            end
            if (in_valid && in_ready && idx < len) idx++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;

        check(done, "R6", "frame ended with out_last", int'(done), 1);
        check(got_n == exp_n, "R2 R3 R4 R6", "frame length", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (got_b[i] !== exp_b[i]) data_err++;
        check(data_err == 0, "R1 R5", "mismatched bytes", data_err, 0);
        check(tail_viol == 0, "R7", "in_ready high in tail", tail_viol, 0);
        if (bp) check(hold_viol == 0, "R8", "stall hold violations", hold_viol, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pad_en = 1'b0; fcs_off = 1'b0; in_add_fcs = 1'b0;
        in_data = '0; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R9", "in_ready follows out_ready", int'(in_ready), 1);
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check(in_ready == 1'b0, "R1", "in_ready follows low out_ready", int'(in_ready), 0);

        for (int v = 0; v < NV; v++) begin
            run_frame(int'(VEC[v][18:11]), VEC[v][10], VEC[v][9], VEC[v][8],
                      int'(VEC[v][7:0]), 1'b0);
        end

        // R5: known trailer for bytes 0x31..0x39
        run_frame(9, 1'b0, 1'b0, 1'b0, 8'h31, 1'b0);
        check({got_b[12], got_b[11], got_b[10], got_b[9]} == 32'hCBF43926, "R5",
              "known trailer", {got_b[12], got_b[11], got_b[10], got_b[9]}, 32'hCBF43926);

        // R8: downstream stalls during data, pad and trailer
        run_frame(20, 1'b1, 1'b0, 1'b0, 8'h05, 1'b1);
        run_frame(61, 1'b0, 1'b0, 1'b0, 8'hC0, 1'b1);

        // R9: back-to-back identical frames give identical output
        run_frame(5, 1'b0, 1'b0, 1'b0, 8'h33, 1'b0);
        run_frame(5, 1'b0, 1'b0, 1'b0, 8'h33, 1'b0);

        // R9: reset in the middle of padding drops the frame
        @(negedge clk);
        pad_en = 1'b1; out_ready = 1'b1;
        in_valid = 1'b1; in_data = 8'h77; in_last = 1'b1; in_add_fcs = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R9", "out_valid after mid-tail reset", int'(out_valid), 0);
        run_frame(3, 1'b1, 1'b0, 1'b0, 8'h44, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule